// File: doc/BRIEF.md
# Control timeslot buffer

This block connects a register port to a single 8-bit control timeslot on a time-division-multiplexed serial stream pair. The serial side is a bit clock and a frame pulse that mark out frames of `SLOTS` timeslots of `BITS` bits each. The block counts bit positions from the frame pulse. In the control timeslot it does two things: it drives a byte onto the output stream and it captures a byte from the input stream. The register port can write and read at any moment. It has no timing relationship with the serial side.

Both directions are double-buffered. A write lands in a holding register. At each frame pulse the holding register is copied into a transmit register, and the transmit register feeds the output stream for that whole frame. While transmit is enabled, the same byte therefore goes out again in every frame. A write made mid-frame first appears in the following frame, and no frame ever carries a mix of two bytes. On the receive side, bits are shifted into a private register. The read buffer is updated only when the last bit of the timeslot has arrived, so a read returns the last complete byte.

The serial inputs are oversampled by the system clock `clk` through two-stage synchronizers. Input data is sampled on the rising edge of the bit clock. The output changes after the falling edge. A frame pulse seen high at a rising edge marks that bit as frame bit 0. `SLOTS` and `BITS` must be powers of two, and `CSLOT` must be at least 1.

Top module: `ctl_slot_buf`

## Requirements
- R1: After reset the read buffer `rd_data_o` is 0, `tx_oe_o` is low and `tx_o` is high.
- R2: With transmit enabled, the transmit byte is driven on `tx_o` during the `BITS` bits of timeslot `CSLOT` of every frame, most significant bit first. It is repeated every frame without a new write.
- R3: A write only updates the holding register. The holding register is copied into the transmit register at the frame pulse, so a write made mid-frame takes effect in the next frame. Every frame carries either the whole old byte or the whole new byte.
- R4: The enable input is sampled at the frame pulse. In a frame where it was low, `tx_oe_o` stays low during the control timeslot, which leaves the output in high impedance.
- R5: `tx_oe_o` is never high outside timeslot `CSLOT`.
- R6: The byte arriving on `rx_i` in timeslot `CSLOT` is assembled most significant bit first. It appears on `rd_data_o` once the last bit of the timeslot has been sampled.
- R7: `rd_data_o` keeps the previous complete byte until the last bit of the timeslot is sampled. It does not change at any other bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial timing |
| rst_n | input | 1 | Active-low reset |
| bclk_i | input | 1 | Serial bit clock |
| fp_i | input | 1 | Frame pulse, high at the rising edge of frame bit 0 |
| rx_i | input | 1 | Input serial stream |
| tx_o | output | 1 | Output serial data |
| tx_oe_o | output | 1 | Output drive enable; low means high impedance |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | BITS | Register write data, goes to the transmit path |
| tx_en_i | input | 1 | Transmit enable for the control timeslot |
| rd_data_o | output | BITS | Last complete received control byte |

## Verification
The bench builds the block with `SLOTS`=4, `BITS`=8 and `CSLOT`=1. A frame then lasts only 32 bits, so 150 frames fit in a short run. Each frame gets a fresh random receive byte, and every bit position is checked for output enable.

In the first phase, writes and enable changes fall at random times, but never close to the frame pulse. This gives an exact expected byte for each frame. In the second phase, writes may land anywhere, including right at the frame boundary. Each frame must then carry exactly the holding value from just before or just after that boundary.

// File: rtl/ctl_slot_buf.sv
module ctl_slot_buf #(
  parameter int SLOTS = 32,
  parameter int BITS  = 8,
  parameter int CSLOT = 1
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bclk_i,
  input  logic            fp_i,
  input  logic            rx_i,
  output logic            tx_o,
  output logic            tx_oe_o,
  input  logic            wr_en_i,
  input  logic [BITS-1:0] wr_data_i,
  input  logic            tx_en_i,
  output logic [BITS-1:0] rd_data_o
);
  localparam int FB      = SLOTS * BITS;
  localparam int PW      = $clog2(FB);
  localparam int IW      = $clog2(BITS);
  localparam int SW      = PW - IW;
  localparam int SLOT_HI = CSLOT * BITS + BITS - 1;

  logic [2:0]      bclk_q;
  logic [1:0]      fp_q, rx_q;
  logic [PW-1:0]   pos, nxt, rx_pos;
  logic [BITS-1:0] hold, tx_sh, rx_sh;
  logic            en_f, rise, fall, frame_ld, rx_in, tx_in;

  assign rise     = bclk_q[1] & ~bclk_q[2];
  assign fall     = ~bclk_q[1] & bclk_q[2];
  assign frame_ld = rise & fp_q[1];
  assign nxt      = pos + 1'b1;
  assign rx_pos   = fp_q[1] ? '0 : nxt;
  assign rx_in    = rx_pos[PW-1:IW] == SW'(CSLOT);
  assign tx_in    = nxt[PW-1:IW] == SW'(CSLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q    <= '0;
      fp_q      <= '0;
      rx_q      <= '0;
      pos       <= PW'(FB - 1);
      hold      <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      rd_data_o <= '0;
      en_f      <= 1'b0;
      tx_o      <= 1'b1;
      tx_oe_o   <= 1'b0;
    end else begin
      bclk_q <= {bclk_q[1:0], bclk_i};
      fp_q   <= {fp_q[0], fp_i};
      rx_q   <= {rx_q[0], rx_i};
      if (wr_en_i) hold <= wr_data_i;
      if (rise) begin
        pos <= rx_pos;
        if (fp_q[1]) begin
          tx_sh <= hold;
          en_f  <= tx_en_i;
        end
        if (rx_in) begin
          rx_sh <= {rx_sh[BITS-2:0], rx_q[1]};
          if (&rx_pos[IW-1:0]) rd_data_o <= {rx_sh[BITS-2:0], rx_q[1]};
        end
      end
      if (fall) begin
        tx_oe_o <= tx_in & en_f;
        tx_o    <= tx_in ? tx_sh[~nxt[IW-1:0]] : 1'b1;
      end
    end
  end
endmodule

module ctl_slot_buf_chk #(
  parameter int BITS = 8,
  parameter int PW   = 8,
  parameter int LAST = 15
)(
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en_i,
  input logic            frame_ld,
  input logic            en_f,
  input logic            tx_oe_o,
  input logic [PW-1:0]   pos,
  input logic [BITS-1:0] hold,
  input logic [BITS-1:0] tx_sh,
  input logic [BITS-1:0] rd_data_o
);
  p_hold_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hold) |-> $past(wr_en_i));

  p_load_at_fp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_sh) |-> $past(frame_ld));

  p_oe_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_oe_o) |-> en_f);

  p_rd_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data_o) |-> pos == PW'(LAST));
endmodule

bind ctl_slot_buf ctl_slot_buf_chk #(.BITS(BITS), .PW(PW), .LAST(SLOT_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .frame_ld(frame_ld), .en_f(en_f),
  .tx_oe_o(tx_oe_o), .pos(pos), .hold(hold), .tx_sh(tx_sh), .rd_data_o(rd_data_o)
);

// File: tb/sim_ctl_slot_buf.sv
`timescale 1ns/1ps
module sim_ctl_slot_buf;
  localparam int SLOTS = 4, BITS = 8, CSLOT = 1;
  localparam int FB = SLOTS * BITS, LO = CSLOT * BITS, HI = LO + BITS - 1;
  localparam int FRAMES = 150, P2 = 80;

  logic clk = 0, rst_n = 0, bclk = 1, fp = 0, rxd = 1, wr_en = 0, tx_en = 0;
  logic [7:0] wr_data = 0;
  logic tx_o, tx_oe;
  logic [7:0] rd;

  always #2.5 clk = ~clk;

  ctl_slot_buf #(.SLOTS(SLOTS), .BITS(BITS), .CSLOT(CSLOT)) u0 (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fp_i(fp), .rx_i(rxd),
    .tx_o(tx_o), .tx_oe_o(tx_oe), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .tx_en_i(tx_en), .rd_data_o(rd));

  int n_cmp = 0, n_bad = 0, phase = 1;
  bit done = 0, guard = 0, m_en = 0, fr_en = 0;
  logic [7:0] m_hold = 0, fr_byte, ha = 0, ha_next = 0, hb, cur_rx, prev_rx = 0, got;
  bit oe_in_ok, oe_out_ok;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(rd == 8'h00, "R1 read buffer", rd, 0);
    chk(tx_oe == 1'b0 && tx_o == 1'b1, "R1 output idle", {tx_oe, tx_o}, 1);
    rst_n = 1;
    repeat (4) @(negedge clk);
    for (int f = 0; f < FRAMES; f++) begin
      cur_rx = 8'($urandom);
      got = 0; oe_in_ok = 1; oe_out_ok = 1;
      for (int p = 0; p < FB; p++) begin
        @(negedge clk);
        bclk = 0;
        fp = (p == 0);
        rxd = (p >= LO && p <= HI) ? cur_rx[HI-p] : 1'($urandom);
        if (p == 0) begin fr_byte = m_hold; fr_en = m_en; ha = ha_next; end
        if (p == 2) begin guard = 0; hb = m_hold; end
        if (p == FB - 2) begin guard = 1; ha_next = m_hold; end
        repeat (7) @(negedge clk);
        if (p >= LO && p <= HI) begin
          got[HI-p] = tx_o;
          if (tx_oe != fr_en) oe_in_ok = 0;
        end else if (tx_oe) oe_out_ok = 0;
        if (p == HI) chk(rd == prev_rx, "R7 no update before last bit", rd, prev_rx);
        if (p == HI + 1) chk(rd == cur_rx, "R6 received byte", rd, cur_rx);
        @(negedge clk);
        bclk = 1;
        repeat (7) @(negedge clk);
      end
      chk(oe_in_ok, fr_en ? "R2 drive in control slot" : "R4 high impedance when disabled", oe_in_ok, 1);
      chk(oe_out_ok, "R5 no drive outside slot", oe_out_ok, 1);
      if (fr_en) begin
        if (phase == 1) chk(got == fr_byte, "R2 R3 transmitted byte", got, fr_byte);
        else chk(got == ha || got == hb, "R3 whole old or new byte", got, {ha, hb});
      end
      prev_rx = cur_rx;
      if (f == P2 - 1) phase = 2;
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(posedge rst_n);
    while (!done) begin
      int gap;
      gap = (phase == 1) ? 10 + int'($urandom % 300) : 80 + int'($urandom % 200);
      repeat (gap) @(negedge clk);
      if (phase == 1 && $urandom % 4 == 0) begin
        while (guard) @(negedge clk);
        tx_en = ~tx_en; m_en = tx_en;
      end else if (phase == 2 && !m_en) begin
        while (guard) @(negedge clk);
        tx_en = 1; m_en = 1;
      end else begin
        if (phase == 1) while (guard) @(negedge clk);
        wr_en = 1; wr_data = 8'($urandom); m_hold = wr_data;
        @(negedge clk);
        wr_en = 0;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule